// File: doc/BRIEF.md
# Break Execution-Count Qualifier

This block sits between a break-condition matcher and the debug logic that takes a break. The matcher pulses a one-cycle match strobe each time its condition is met. Software can load a count through a 16-bit register port. When the qualified mode is enabled, the block does not pass every match on as a break. Each match first lowers the count by one. A break is requested only on a match that arrives while the count already stands at one.

On that match the count stays at one, so each later match breaks again until software loads a new value. A count of zero leaves the qualifier disarmed. When the qualified mode input is low, the count is bypassed and every match produces a break.

The break request is a registered, one-cycle pulse. The count can always be read back through the same register port. The upper four bits of that register are reserved and read as zero.

Top module: `brk_exec_qual`

## Requirements
- R1: After reset the count is 0, `rd_data` reads 0x0000 and `brk_o` is low.
- R2: A write with `wr_en` high stores `wr_data[11:0]` as the count. `rd_data[11:0]` shows the count and `rd_data[15:12]` always reads 0, whatever was written to those bits.
- R3: With `qual_en` high, a match while the count is greater than 1 lowers the count by exactly 1 and gives no break.
- R4: With `qual_en` high, a match while the count equals 1 drives `brk_o` high in the next cycle, and the count stays at 1.
- R5: With `qual_en` high, a match while the count is 0 gives no break and leaves the count at 0.
- R6: With `qual_en` low, every match drives `brk_o` high in the next cycle and leaves the count unchanged.
- R7: When `wr_en` and `match_i` are high in the same cycle, the write takes effect and the match is dropped: there is no break and no decrement.
- R8: `brk_o` is high only in the cycle after an accepted, firing match. With no match in a cycle, `brk_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data; bits 11:0 are the count |
| rd_data | output | 16 | Register readback: count in bits 11:0, zeros above |
| match_i | input | 1 | One-cycle break-condition match strobe |
| qual_en | input | 1 | 1: count-qualified breaks; 0: every match breaks |
| brk_o | output | 1 | One-cycle break request |

## Verification
A count register holding the wrong value shows up at `rd_data` in the cycle after the faulty update. A bench that compares every cycle therefore catches a wrong decrement step at once. A break decision taken from a stale or off-by-one count would show as a missing or extra `brk_o` pulse exactly one cycle after the match. Two cases are driven on purpose because they only appear at the edges: the one-to-one hold and the write-over-match collision. Each is then followed by further matches, so a wrong count carried forward also shows at the next break.

// File: rtl/brk_cnt_pkg.sv
package brk_cnt_pkg;

  // Count value after an accepted match in qualified mode.
  // Counts above one step down; one holds; zero stays disarmed.
  function automatic int unsigned cnt_after_match(input int unsigned cnt);
    if (cnt > 1) return cnt - 1;
    return cnt;
  endfunction

  // Whether an accepted match produces a break request.
  function automatic logic match_fires(input logic qual, input int unsigned cnt);
    return (!qual) || (cnt == 1);
  endfunction

endpackage

// File: rtl/brk_cnt_regport.sv
module brk_cnt_regport #(
  parameter int CNT_W = 12,
  parameter int REG_W = 16
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             load_en,
  output logic [CNT_W-1:0] load_val,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - CNT_W;

  assign load_en  = wr_en;
  assign load_val = wr_data[CNT_W-1:0];

  generate
    if (PAD_W > 0) begin : g_pad
      logic reserved_unused;
      assign reserved_unused = ^wr_data[REG_W-1:CNT_W];
      assign rd_data = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_nopad
      assign rd_data = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/brk_cnt_core.sv
module brk_cnt_core
  import brk_cnt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             match_i,
  input  logic             qual_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_acc,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_step;

  // A write in the same cycle wins over the match.
  assign match_acc = match_i & ~load_en;
  assign fire      = match_acc & match_fires(qual_en, 32'(cnt_q));
  assign cnt_step  = CNT_W'(cnt_after_match(32'(cnt_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (match_acc && qual_en) begin
      cnt_q <= cnt_step;
    end
  end
endmodule

// File: rtl/brk_pulse_reg.sv
module brk_pulse_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic brk_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_o <= 1'b0;
    else        brk_o <= fire;
  end
endmodule

// File: rtl/brk_exec_qual.sv
module brk_exec_qual #(
  parameter int CNT_W = 12,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             match_i,
  input  logic             qual_en,
  output logic             brk_o
);
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             match_acc;
  logic             fire;

  brk_cnt_regport #(.CNT_W(CNT_W), .REG_W(REG_W)) u_regport (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cnt_q    (cnt_q),
    .load_en  (load_en),
    .load_val (load_val),
    .rd_data  (rd_data)
  );

  brk_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (load_val),
    .match_i   (match_i),
    .qual_en   (qual_en),
    .cnt_q     (cnt_q),
    .match_acc (match_acc),
    .fire      (fire)
  );

  brk_pulse_reg u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .brk_o (brk_o)
  );
endmodule

// File: rtl/brk_exec_qual_chk.sv
module brk_exec_qual_chk #(
  parameter int CNT_W = 12,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             match_i,
  input logic             qual_en,
  input logic             brk_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             match_acc
);
  always_comb begin
    if (rst_n) begin
      assert_reserved_zero_R2: assert (rd_data[REG_W-1:CNT_W] == '0);
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data[CNT_W-1:0]));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !wr_en && qual_en && cnt_q > 1) |=> (cnt_q == $past(cnt_q) - 1'b1) && !brk_o);

  assert_fire_at_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !wr_en && qual_en && cnt_q == 1) |=> brk_o && cnt_q == 1);

  assert_disarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !wr_en && qual_en && cnt_q == 0) |=> !brk_o && cnt_q == 0);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !wr_en && !qual_en) |=> brk_o && $stable(cnt_q));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && match_i) |=> !brk_o);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_acc |=> !brk_o);
endmodule

bind brk_exec_qual brk_exec_qual_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .match_i   (match_i),
  .qual_en   (qual_en),
  .brk_o     (brk_o),
  .cnt_q     (cnt_q),
  .match_acc (match_acc)
);

// File: tb/brk_exec_qual_tb.sv
`timescale 1ns/1ps
module brk_exec_qual_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        match_i = 1'b0;
  logic        qual_en = 1'b0;
  logic        brk_o;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  bit m_brk  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  brk_exec_qual u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .match_i(match_i), .qual_en(qual_en), .brk_o(brk_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Requirement that governs one stimulus cycle, from the model's view.
  function automatic string tag_of(input bit w, input bit m, input bit q, input int c);
    if (w && m) return "R7";
    if (w)      return "R2";
    if (!m)     return "R8";
    if (!q)     return "R6";
    if (c == 0) return "R5";
    if (c == 1) return "R4";
    return "R3";
  endfunction

  task automatic step(input bit w, input logic [15:0] d, input bit m, input bit q);
    string t;
    wr_en = w; wr_data = d; match_i = m; qual_en = q;
    t = tag_of(w, m, q, m_cnt);
    @(posedge clk);
    // Behavioural reference: write beats match; qualified count rules.
    if (w) begin
      m_cnt = int'(d) % 4096;
      m_brk = 0;
    end else if (m) begin
      if (!q) m_brk = 1;
      else begin
        m_brk = (m_cnt == 1);
        if (m_cnt > 1) m_cnt = m_cnt - 1;
      end
    end else m_brk = 0;
    @(negedge clk);
    wr_en = 0; match_i = 0;
    check(t, int'(brk_o), int'(m_brk), "brk_o");
    check(t, int'(rd_data), m_cnt, "rd_data");
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(rd_data), 0, "rd_data in reset");
    check("R1", int'(brk_o), 0, "brk_o in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(rd_data), 0, "rd_data after reset");
    // R2: reserved bits dropped on write and read as zero
    step(1, 16'hFFFF, 0, 1);
    step(1, 16'hA005, 0, 1);
    // R3 then R4: count 5 down to 1, then repeated breaks at 1
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    // R5: disarmed at zero
    step(1, 16'h0000, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    // R6: bypass with non-trivial count
    step(1, 16'h0007, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    // R7: write collides with match at count 1
    step(1, 16'h0001, 0, 1);
    step(1, 16'h0002, 1, 1);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    // boundary: maximum count steps down
    step(1, 16'h0FFF, 0, 1);
    step(0, 0, 1, 1);
    // mixed traffic on small counts
    for (int i = 0; i < 400; i++) begin
      automatic bit w = ($urandom % 8) == 0;
      step(w, 16'($urandom % 5) | 16'($urandom & 32'hF000), ($urandom % 2) == 1,
           ($urandom % 4) != 0);
    end
    // R8: idle cycles never break
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule